// File: doc/BRIEF.md
# Immediate Extend and Address Unit

This unit sits in the execute stage of a 32-bit load/store datapath. It takes the 16-bit immediate field of an instruction and widens it to a full 32-bit operand. The widening rule depends on the instruction class. Arithmetic immediates (add, subtract, multiply) are widened signed, by copying the top bit. Logical immediates (AND, OR, XOR) are widened with zeros. For word loads and stores, the unit adds the signed offset to a base register value to form a byte address. It also flags whether that address falls on a word boundary.

Memory is byte-addressed with four bytes per word, stored most significant byte first. The unit therefore also carries two byte-order converters. One splits an outgoing 32-bit word into four address-ordered byte lanes. The other assembles four incoming address-ordered byte lanes into a 32-bit word.

The datapath logic is combinational. All results are captured in one output register stage, so every output shows the inputs sampled at the previous rising clock edge.

Top module: `ixu_top`

## Requirements
- R1: While `rst_n` is low, every output is zero, and asserting `rst_n` low takes effect without waiting for a clock edge.
- R2: With `mode_i` = 2'b00 (signed immediate), `operand_o` equals `imm_i` with bit 15 copied into bits 31..16.
- R3: With `mode_i` = 2'b01 (logical immediate), `operand_o` equals `imm_i` in bits 15..0, and bits 31..16 are zero.
- R4: With `mode_i` = 2'b10 (address generation), `addr_o` equals `base_i` plus the sign-extended `imm_i`, modulo 2^32, and `operand_o` equals the sign-extended `imm_i`.
- R5: With `mode_i` = 2'b10, `misalign_o` is 1 exactly when bit 1 or bit 0 of the computed address is nonzero.
- R6: When `mode_i` is not 2'b10, `addr_o` and `misalign_o` are zero whatever `base_i` holds.
- R7: With `mode_i` = 2'b11 (reserved), `operand_o` is zero.
- R8: `wr_bytes_o` lane k (bits 8k+7..8k, lane 0 being the lowest byte address) holds the byte of `wr_word_i` at bits 31-8k..24-8k, so lane 0 carries the most significant byte.
- R9: `rd_word_o` bits 31..24 come from `rd_bytes_i` lane 0, bits 23..16 from lane 1, bits 15..8 from lane 2 and bits 7..0 from lane 3.
- R10: Outside reset, each output reflects the inputs sampled at the previous rising edge of `clk`. This is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 signed immediate, 01 logical immediate, 10 address generation, 11 reserved |
| imm_i | input | 16 | Instruction immediate field |
| base_i | input | 32 | Base register value for address generation |
| wr_word_i | input | 32 | Word to be split into address-ordered bytes |
| rd_bytes_i | input | 32 | Four address-ordered byte lanes, lane 0 in bits 7..0 |
| operand_o | output | 32 | Extended immediate operand |
| addr_o | output | 32 | Effective byte address |
| misalign_o | output | 1 | Address is not a multiple of 4 |
| wr_bytes_o | output | 32 | Byte lanes of `wr_word_i`, lane 0 in bits 7..0 |
| rd_word_o | output | 32 | Word assembled from `rd_bytes_i` |

## Verification
The immediate is driven with values just below and at the sign boundary (7FFF, 8000, FFFF) in both extension modes. This separates signed widening from zero widening, and catches an inverted mode decode. Address generation is tried with positive and negative offsets, with sums that wrap past 2^32 in both directions, and with each nonzero value of the low two address bits. This separates a correct carry chain and alignment test from a truncated one. A misaligned base is fed in non-address modes to show it has no effect, and distinct per-byte patterns in the byte converters expose any swapped or duplicated lane.

// File: rtl/ixu_pkg.sv
package ixu_pkg;

  typedef enum logic [1:0] {
    MODE_SEXT = 2'b00,
    MODE_ZEXT = 2'b01,
    MODE_ADDR = 2'b10,
    MODE_RSVD = 2'b11
  } ixu_mode_e;

endpackage

// File: rtl/ixu_extend.sv
// Widens an immediate to the datapath width, either signed or unsigned.
module ixu_extend #(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] ext_o
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic fill_bit;

  assign fill_bit = signed_i & imm_i[IMM_W-1];
  assign ext_o    = {{PAD_W{fill_bit}}, imm_i};

endmodule

// File: rtl/ixu_agen.sv
// Base plus offset adder with a word-alignment test on the low bits.
module ixu_agen #(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] ofs_i,
  output logic [DATA_W-1:0] addr_o,
  output logic              misalign_o
);

  assign addr_o     = base_i + ofs_i;
  assign misalign_o = |addr_o[ALIGN_BITS-1:0];

endmodule

// File: rtl/ixu_be_swap.sv
// Reverses byte order between a numeric word and address-ordered lanes.
// The mapping is its own inverse, so it serves both directions.
module ixu_be_swap #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [LANES*BYTE_W-1:0] in_i,
  output logic [LANES*BYTE_W-1:0] out_o
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign out_o[k*BYTE_W +: BYTE_W] = in_i[(LANES-1-k)*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/ixu_top.sv
module ixu_top #(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] wr_word_i,
  input  logic [DATA_W-1:0] rd_bytes_i,
  output logic [DATA_W-1:0] operand_o,
  output logic [DATA_W-1:0] addr_o,
  output logic              misalign_o,
  output logic [DATA_W-1:0] wr_bytes_o,
  output logic [DATA_W-1:0] rd_word_o
);

  import ixu_pkg::*;

  localparam int LANES      = DATA_W / BYTE_W;
  localparam int ALIGN_BITS = $clog2(LANES);

  ixu_mode_e         mode;
  logic              use_signed;
  logic [DATA_W-1:0] ext_w;
  logic [DATA_W-1:0] ea_w;
  logic              ea_mis_w;
  logic [DATA_W-1:0] wr_bytes_w;
  logic [DATA_W-1:0] rd_word_w;

  logic [DATA_W-1:0] operand_d;
  logic [DATA_W-1:0] addr_d;
  logic              misalign_d;

  assign mode       = ixu_mode_e'(mode_i);
  assign use_signed = (mode != MODE_ZEXT);

  ixu_extend #(
    .IMM_W  (IMM_W),
    .DATA_W (DATA_W)
  ) u_ext (
    .imm_i    (imm_i),
    .signed_i (use_signed),
    .ext_o    (ext_w)
  );

  ixu_agen #(
    .DATA_W     (DATA_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_agen (
    .base_i     (base_i),
    .ofs_i      (ext_w),
    .addr_o     (ea_w),
    .misalign_o (ea_mis_w)
  );

  ixu_be_swap #(
    .LANES  (LANES),
    .BYTE_W (BYTE_W)
  ) u_wr_swap (
    .in_i  (wr_word_i),
    .out_o (wr_bytes_w)
  );

  ixu_be_swap #(
    .LANES  (LANES),
    .BYTE_W (BYTE_W)
  ) u_rd_swap (
    .in_i  (rd_bytes_i),
    .out_o (rd_word_w)
  );

  // Next-state selection by instruction class
  always_comb begin
    operand_d  = '0;
    addr_d     = '0;
    misalign_d = 1'b0;
    unique case (mode)
      MODE_SEXT: operand_d = ext_w;
      MODE_ZEXT: operand_d = ext_w;
      MODE_ADDR: begin
        operand_d  = ext_w;
        addr_d     = ea_w;
        misalign_d = ea_mis_w;
      end
      default: ;
    endcase
  end

  // Output register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      operand_o  <= '0;
      addr_o     <= '0;
      misalign_o <= 1'b0;
      wr_bytes_o <= '0;
      rd_word_o  <= '0;
    end else begin
      operand_o  <= operand_d;
      addr_o     <= addr_d;
      misalign_o <= misalign_d;
      wr_bytes_o <= wr_bytes_w;
      rd_word_o  <= rd_word_w;
    end
  end

endmodule

// File: rtl/ixu_top_chk.sv
module ixu_top_chk #(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] base_i,
  input logic [DATA_W-1:0] wr_word_i,
  input logic [DATA_W-1:0] rd_bytes_i,
  input logic [DATA_W-1:0] operand_o,
  input logic [DATA_W-1:0] addr_o,
  input logic              misalign_o,
  input logic [DATA_W-1:0] wr_bytes_o,
  input logic [DATA_W-1:0] rd_word_o
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1: outputs are cleared while reset is held
  a_r1_reset_clear: assert property (@(negedge clk)
    !rst_n |-> (operand_o == '0 && addr_o == '0 && !misalign_o &&
                wr_bytes_o == '0 && rd_word_o == '0));

  // R2, R10
  a_r2_sign_extend: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_i) == 2'b00 |->
      operand_o == {{PAD_W{$past(imm_i[IMM_W-1])}}, $past(imm_i)});

  // R3
  a_r3_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_i) == 2'b01 |->
      operand_o == {{PAD_W{1'b0}}, $past(imm_i)});

  // R4
  a_r4_eff_addr: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_i) == 2'b10 |->
      addr_o == $past(base_i) + {{PAD_W{$past(imm_i[IMM_W-1])}}, $past(imm_i)});

  // R5
  a_r5_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_i) == 2'b10 |-> misalign_o == (addr_o[1:0] != 2'b00));

  // R6
  a_r6_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_i) != 2'b10 |-> addr_o == '0 && !misalign_o);

  // R7
  a_r7_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_i) == 2'b11 |-> operand_o == '0);

  // R8
  a_r8_wr_order: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> wr_bytes_o[7:0] == $past(wr_word_i[DATA_W-1 -: 8]) &&
                wr_bytes_o[DATA_W-1 -: 8] == $past(wr_word_i[7:0]));

  // R9
  a_r9_rd_order: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> rd_word_o[DATA_W-1 -: 8] == $past(rd_bytes_i[7:0]) &&
                rd_word_o[7:0] == $past(rd_bytes_i[DATA_W-1 -: 8]));

endmodule

bind ixu_top ixu_top_chk #(
  .IMM_W  (IMM_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .imm_i      (imm_i),
  .base_i     (base_i),
  .wr_word_i  (wr_word_i),
  .rd_bytes_i (rd_bytes_i),
  .operand_o  (operand_o),
  .addr_o     (addr_o),
  .misalign_o (misalign_o),
  .wr_bytes_o (wr_bytes_o),
  .rd_word_o  (rd_word_o)
);

// File: tb/tb_ixu_top.sv
`timescale 1ns/1ps
module tb_ixu_top;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic [15:0] imm_i;
  logic [31:0] base_i;
  logic [31:0] wr_word_i;
  logic [31:0] rd_bytes_i;
  logic [31:0] operand_o;
  logic [31:0] addr_o;
  logic        misalign_o;
  logic [31:0] wr_bytes_o;
  logic [31:0] rd_word_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ixu_top dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .imm_i      (imm_i),
    .base_i     (base_i),
    .wr_word_i  (wr_word_i),
    .rd_bytes_i (rd_bytes_i),
    .operand_o  (operand_o),
    .addr_o     (addr_o),
    .misalign_o (misalign_o),
    .wr_bytes_o (wr_bytes_o),
    .rd_word_o  (rd_word_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {mode, imm, base, expected operand, expected addr, expected misalign}
  localparam int NV = 12;
  localparam logic [114:0] VEC [NV] = '{
    {2'b00, 16'h7FFF, 32'h0000_0000, 32'h0000_7FFF, 32'h0000_0000, 1'b0}, // R2
    {2'b00, 16'h8000, 32'h0000_0000, 32'hFFFF_8000, 32'h0000_0000, 1'b0}, // R2
    {2'b01, 16'h8000, 32'h0000_0000, 32'h0000_8000, 32'h0000_0000, 1'b0}, // R3
    {2'b01, 16'hFFFF, 32'h0000_0000, 32'h0000_FFFF, 32'h0000_0000, 1'b0}, // R3
    {2'b10, 16'h0004, 32'h0000_1000, 32'h0000_0004, 32'h0000_1004, 1'b0}, // R4
    {2'b10, 16'hFFFC, 32'h0000_1000, 32'hFFFF_FFFC, 32'h0000_0FFC, 1'b0}, // R4
    {2'b10, 16'h0001, 32'h0000_2000, 32'h0000_0001, 32'h0000_2001, 1'b1}, // R5
    {2'b10, 16'h0002, 32'h0000_0000, 32'h0000_0002, 32'h0000_0002, 1'b1}, // R5
    {2'b10, 16'hFFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1}, // R4 wrap
    {2'b10, 16'h0008, 32'hFFFF_FFF8, 32'h0000_0008, 32'h0000_0000, 1'b0}, // R4 wrap
    {2'b11, 16'h1234, 32'h0000_0055, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R7
    {2'b00, 16'h0001, 32'h0000_1003, 32'h0000_0001, 32'h0000_0000, 1'b0}  // R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [15:0] im, input logic [31:0] b,
                       input logic [31:0] ww, input logic [31:0] rb);
    @(negedge clk);
    mode_i = m; imm_i = im; base_i = b; wr_word_i = ww; rd_bytes_i = rb;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mode_i = 2'b10; imm_i = 16'h0003; base_i = 32'h1111_1111;
    wr_word_i = 32'hDEAD_BEEF; rd_bytes_i = 32'hCAFE_F00D;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state with busy inputs
    chk("R1 operand in reset", operand_o, 32'h0);
    chk("R1 addr in reset", addr_o, 32'h0);
    chk("R1 misalign in reset", {31'h0, misalign_o}, 32'h0);
    chk("R1 bytes in reset", wr_bytes_o, 32'h0);
    chk("R1 word in reset", rd_word_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R2..R7 and R10 (value visible one edge after drive)
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][114:113], VEC[i][112:97], VEC[i][96:65], 32'h0, 32'h0);
      chk($sformatf("R10/R2-7 vec%0d operand", i), operand_o, VEC[i][64:33]);
      chk($sformatf("R4/R6 vec%0d addr", i), addr_o, VEC[i][32:1]);
      chk($sformatf("R5/R6 vec%0d misalign", i), {31'h0, misalign_o}, {31'h0, VEC[i][0]});
    end

    // R5: low bits 11
    apply(2'b10, 16'h0003, 32'h0000_0100, 32'h0, 32'h0);
    chk("R5 low bits 11", {31'h0, misalign_o}, 32'h1);
    chk("R4 addr 0x103", addr_o, 32'h0000_0103);

    // R6: logical mode with misaligned base
    apply(2'b01, 16'h0001, 32'h0000_0007, 32'h0, 32'h0);
    chk("R6 addr zero in logical mode", addr_o, 32'h0);
    chk("R6 misalign zero in logical mode", {31'h0, misalign_o}, 32'h0);

    // R8, R9: byte ordering with distinct bytes
    apply(2'b00, 16'h0000, 32'h0, 32'h1122_3344, 32'hDDCC_BBAA);
    chk("R8 wr lanes", wr_bytes_o, 32'h4433_2211);
    chk("R9 rd word", rd_word_o, 32'hAABB_CCDD);
    apply(2'b00, 16'h0000, 32'h0, 32'h0102_8040, 32'h0000_00FF);
    chk("R8 wr lanes 2", wr_bytes_o, 32'h4080_0201);
    chk("R9 rd word 2", rd_word_o, 32'hFF00_0000);

    // R10: output holds old value until the next edge
    @(negedge clk);
    mode_i = 2'b01; imm_i = 16'hABCD;
    #1;
    chk("R10 no change before edge", operand_o, 32'h0000_0000);
    @(posedge clk);
    #2;
    chk("R10 change after edge", operand_o, 32'h0000_ABCD);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1 async clear operand", operand_o, 32'h0);
    chk("R1 async clear word", rd_word_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule